// File: doc/BRIEF.md
# Sixteen-Function Signed ALU

This block is a purely combinational arithmetic logic unit. It takes two 16-bit two's-complement operands and a 4-bit function code. From these it produces a 16-bit result and a one-bit overflow flag in the same cycle. It has no registers, so a parent pipeline decides where its inputs and outputs are captured.

The sixteen functions fall into four groups:

- signed add and subtract;
- eight bitwise logic forms;
- single-position shifts;
- a small set of unary and constant results.

The overflow flag reports only signed add and subtract results that cannot be represented in 16 bits. For every other function the flag is forced low.

Top module: `alu16_core`

## Requirements
- R1: Code 0 (4'h0) gives the sum of the two operands, wrapped to 16 bits.
- R2: Code 1 (4'h1) gives the first operand minus the second, wrapped to 16 bits.
- R3: With code 0, the flag is 1 exactly when both operands share a sign and the 16-bit result has the other sign.
- R4: With code 1, the flag is 1 exactly when the operands differ in sign and the 16-bit result's sign differs from the first operand's sign.
- R5: For codes 2 through 15, the flag is 0 whatever the operands.
- R6: Code 2 passes the first operand through unchanged, and code 3 gives its bitwise inverse.
- R7: Codes 4, 5, 6 and 7 give, in that order, bitwise AND, OR, NAND and NOR of the operands.
- R8: Code 8 gives bitwise XOR of the operands, and code 9 gives its inverse (XNOR).
- R9: Code 10 shifts the first operand left one place and fills bit 0 with zero. Code 11 shifts it right one place and fills bit 15 with zero.
- R10: Code 12 gives the same result as code 10. Code 13 shifts the first operand right one place and keeps bit 15 at its old value.
- R11: Code 14 gives the two's-complement negation of the first operand. Negating 16'h8000 gives 16'h8000 with the flag at 0.
- R12: Code 15 gives a result of zero for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand, two's complement |
| opnd_b | input | 16 | Second operand, two's complement |
| func_sel | input | 4 | Function code |
| alu_result | output | 16 | Result of the selected function |
| ovf_flag | output | 1 | Signed overflow of add or subtract |

## Verification
The result bus and the overflow flag change together, and they interact when an add or subtract wraps. In that case the result must hold the wrapped 16-bit value while the flag is raised for the same operands. The bench provokes this with operand pairs built from 16'h7FFF, 16'h8000, 16'hFFFF, 0 and 1, together with random pairs, under every function code. Each response is judged on both outputs at once against a model that works in full-width integers, so a wrong flag on a correct result, or the reverse, is reported.

// File: rtl/alu16_pkg.sv
// Package: shared width and function-code encoding for the ALU.
// Assumes the code values are fixed by the surrounding instruction decode.
package alu16_pkg;
    localparam int unsigned ALU_W  = 16;
    localparam int unsigned CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        FN_ADD  = 4'h0,
        FN_SUB  = 4'h1,
        FN_PASS = 4'h2,
        FN_INV  = 4'h3,
        FN_AND  = 4'h4,
        FN_OR   = 4'h5,
        FN_NAND = 4'h6,
        FN_NOR  = 4'h7,
        FN_XOR  = 4'h8,
        FN_XNOR = 4'h9,
        FN_SLL  = 4'hA,
        FN_SRL  = 4'hB,
        FN_SLA  = 4'hC,
        FN_SRA  = 4'hD,
        FN_NEG  = 4'hE,
        FN_ZERO = 4'hF
    } alu_fn_e;
endpackage

// File: rtl/alu16_addsub.sv
// Module: shared adder for signed add and subtract, with separate overflow
// indications for each. Assumes two's-complement operands of width W.
module alu16_addsub #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_val,
    input  logic [W-1:0] b_val,
    input  logic         do_sub,
    output logic [W-1:0] sum_out,
    output logic         ovf_add,
    output logic         ovf_sub
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] b_eff;

    // Invert B and inject a carry to form A - B on the same adder.
    always_comb begin
        b_eff   = do_sub ? ~b_val : b_val;
        sum_out = a_val + b_eff + {{(W-1){1'b0}}, do_sub};
    end

    // Sign-based overflow detection for each arithmetic form.
    always_comb begin
        ovf_add = (a_val[MSB] == b_val[MSB]) && (sum_out[MSB] != a_val[MSB]);
        ovf_sub = (a_val[MSB] != b_val[MSB]) && (sum_out[MSB] != a_val[MSB]);
    end
endmodule

// File: rtl/alu16_bitwise.sv
// Module: the eight bitwise logic functions, selected by the function code.
// Assumes codes outside the logic group are don't-care here (output zero).
module alu16_bitwise
    import alu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_val,
    input  logic [W-1:0] b_val,
    input  alu_fn_e      fn,
    output logic [W-1:0] logic_out
);
    // Pick one bitwise form of A and B.
    always_comb begin
        unique case (fn)
            FN_PASS: logic_out = a_val;
            FN_INV:  logic_out = ~a_val;
            FN_AND:  logic_out = a_val & b_val;
            FN_OR:   logic_out = a_val | b_val;
            FN_NAND: logic_out = ~(a_val & b_val);
            FN_NOR:  logic_out = ~(a_val | b_val);
            FN_XOR:  logic_out = a_val ^ b_val;
            FN_XNOR: logic_out = ~(a_val ^ b_val);
            default: logic_out = '0;
        endcase
    end
endmodule

// File: rtl/alu16_unary.sv
// Module: one-place shifts, negation and the constant zero, all on A only.
// Assumes a shift distance of exactly one; left arithmetic equals left logical.
module alu16_unary
    import alu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_val,
    input  alu_fn_e      fn,
    output logic [W-1:0] unary_out
);
    localparam int unsigned MSB = W - 1;

    // Pick a shift, negation or zero result from A.
    always_comb begin
        unique case (fn)
            FN_SLL, FN_SLA: unary_out = {a_val[MSB-1:0], 1'b0};
            FN_SRL:         unary_out = {1'b0, a_val[MSB:1]};
            FN_SRA:         unary_out = {a_val[MSB], a_val[MSB:1]};
            FN_NEG:         unary_out = ~a_val + {{(W-1){1'b0}}, 1'b1};
            default:        unary_out = '0;
        endcase
    end
endmodule

// File: rtl/alu16_core.sv
// Module: top of the ALU. Routes the function code to the adder, bitwise
// and unary units and forms the overflow flag. Purely combinational.
module alu16_core
    import alu16_pkg::*;
#(
    parameter int unsigned W = ALU_W
) (
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic [CODE_W-1:0] func_sel,
    output logic [W-1:0]      alu_result,
    output logic              ovf_flag
);
    localparam int unsigned MSB = W - 1;

    alu_fn_e      fn;
    logic [W-1:0] arith_res, logic_res, unary_res;
    logic         add_ovf, sub_ovf;

    // Decode the raw code into the enumerated function.
    always_comb fn = alu_fn_e'(func_sel);

    alu16_addsub #(.W(W)) u_addsub (
        .a_val   (opnd_a),
        .b_val   (opnd_b),
        .do_sub  (fn == FN_SUB),
        .sum_out (arith_res),
        .ovf_add (add_ovf),
        .ovf_sub (sub_ovf)
    );

    alu16_bitwise #(.W(W)) u_bitwise (
        .a_val     (opnd_a),
        .b_val     (opnd_b),
        .fn        (fn),
        .logic_out (logic_res)
    );

    alu16_unary #(.W(W)) u_unary (
        .a_val     (opnd_a),
        .fn        (fn),
        .unary_out (unary_res)
    );

    // Steer the unit that owns the code to the result port.
    always_comb begin
        if (fn == FN_ADD || fn == FN_SUB) begin
            alu_result = arith_res;
        end else if (fn >= FN_SLL) begin
            alu_result = unary_res;
        end else begin
            alu_result = logic_res;
        end
    end

    // Overflow only for the two arithmetic codes.
    always_comb begin
        unique case (fn)
            FN_ADD:  ovf_flag = add_ovf;
            FN_SUB:  ovf_flag = sub_ovf;
            default: ovf_flag = 1'b0;
        endcase
    end

    // Widened reference arithmetic used only by the assertions below.
    logic [W:0] wide_add, wide_sub;
    always_comb begin
        wide_add = {opnd_a[MSB], opnd_a} + {opnd_b[MSB], opnd_b};
        wide_sub = {opnd_a[MSB], opnd_a} - {opnd_b[MSB], opnd_b};
    end

    // Immediate checks of port relations for each function group.
    always_comb begin
        if (fn == FN_ADD) begin
            AST_ADD_WRAP: assert (alu_result == wide_add[MSB:0]); // R1
            AST_ADD_OVF:  assert (ovf_flag == (wide_add[W] != wide_add[MSB])); // R3
        end
        if (fn == FN_SUB) begin
            AST_SUB_WRAP: assert (alu_result == wide_sub[MSB:0]); // R2
            AST_SUB_OVF:  assert (ovf_flag == (wide_sub[W] != wide_sub[MSB])); // R4
        end
        if (fn != FN_ADD && fn != FN_SUB) begin
            AST_NO_OVERFLOW: assert (!ovf_flag); // R5
        end
        if (fn == FN_SRA) begin
            AST_SRA_SIGN: assert (alu_result[MSB] == opnd_a[MSB]); // R10
        end
        if (fn == FN_NEG) begin
            AST_NEG_SUM: assert ((alu_result + opnd_a) == '0); // R11
        end
        if (fn == FN_ZERO) begin
            AST_ZERO_OUT: assert (alu_result == '0); // R12
        end
    end
endmodule

// File: tb/alu16_core_tb.sv
// Bench: behavioural integer model of the ALU, compared once per clock.
module alu16_core_tb;
    logic        clk = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [3:0]  func_sel = '0;
    logic [15:0] alu_result;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit summary_done = 1'b0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    alu16_core u_dut (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .func_sel   (func_sel),
        .alu_result (alu_result),
        .ovf_flag   (ovf_flag)
    );

    function automatic string req_of(input int code);
        case (code)
            0: return "R1/R3";
            1: return "R2/R4";
            2, 3: return "R6/R5";
            4, 5, 6, 7: return "R7/R5";
            8, 9: return "R8/R5";
            10, 11: return "R9/R5";
            12, 13: return "R10/R5";
            14: return "R11/R5";
            default: return "R12/R5";
        endcase
    endfunction

    // Reference: {flag, result} computed with wide integers.
    function automatic logic [16:0] model(input logic [15:0] a, input logic [15:0] b, input int code);
        int sa, sb, full, ua;
        logic [15:0] r;
        logic f;
        sa = int'($signed(a));
        sb = int'($signed(b));
        ua = int'(a);
        f = 1'b0;
        case (code)
            0: begin full = sa + sb; r = full[15:0]; f = (full > 32767) || (full < -32768); end
            1: begin full = sa - sb; r = full[15:0]; f = (full > 32767) || (full < -32768); end
            2: r = a;
            3: r = ~a;
            4: r = a & b;
            5: r = a | b;
            6: r = ~(a & b);
            7: r = ~(a | b);
            8: r = a ^ b;
            9: r = ~(a ^ b);
            10, 12: begin full = ua * 2; r = full[15:0]; end
            11: begin full = ua / 2; r = full[15:0]; end
            13: begin full = (sa < 0) ? -((-sa + 1) / 2) : sa / 2; r = full[15:0]; end
            14: begin full = -sa; r = full[15:0]; end
            default: r = 16'h0000;
        endcase
        return {f, r};
    endfunction

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input int code);
        logic [16:0] exp;
        @(posedge clk);
        #1;
        opnd_a = a;
        opnd_b = b;
        func_sel = 4'(code);
        @(negedge clk);
        exp = model(a, b, code);
        checks++;
        if ({ovf_flag, alu_result} !== exp) begin
            errors++;
            $display("FAIL %s code=%0d a=%h b=%h actual flag=%b res=%h expected flag=%b res=%h",
                     req_of(code), code, a, b, ovf_flag, alu_result, exp[16], exp[15:0]);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    logic [15:0] corners [8];
    initial begin
        corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'hFFFF;
        corners[3] = 16'h7FFF; corners[4] = 16'h8000; corners[5] = 16'h8001;
        corners[6] = 16'h7FFE; corners[7] = 16'hA5C3;
        // Initial state: all-zero inputs give zero result, flag low (R1, R5).
        apply(16'h0000, 16'h0000, 0);
        // Named corners: R3 positive wrap, R4 subtract wrap, R11 most negative.
        apply(16'h7FFF, 16'h0001, 0);
        apply(16'h8000, 16'h0001, 1);
        apply(16'h8000, 16'h0000, 14);
        apply(16'h8001, 16'h0000, 13);
        apply(16'hFFFF, 16'h1234, 15);
        // Full sweep of every code over all corner pairs.
        for (int code = 0; code < 16; code++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(corners[i], corners[j], code);
        // Random operands under every code.
        for (int n = 0; n < 200; n++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom());
            rb = 16'($urandom());
            for (int code = 0; code < 16; code++) apply(ra, rb, code);
        end
        done = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end
endmodule